// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous request port, used by a single master, to an external asynchronous static RAM. The RAM holds 131,072 words of sixteen bits. The master offers one read or write at a time. Each request carries a 17-bit word address, 16 bits of write data and a per-byte enable mask. The controller turns the request into the RAM's active-low chip-select, read-strobe, write-strobe and per-lane select signals. It also runs a separate drive-enable for the bidirectional data pins, so that the pad ring can build the tri-state buffer outside this block.

Every strobe is held for a whole number of clock cycles. That number comes from two parameters, the clock period and the access time in nanoseconds: `WAIT = ceil(ACCESS_NS / CLK_NS) + 1`. With the defaults (10 ns clock, 70 ns access) `WAIT` is 8. A read returns its data on `rd_data` together with a single-cycle `rd_valid` pulse. Byte lanes that were not selected read back as zero.

The control is one state machine with six states:
- `ST_IDLE`: ready for a request; the RAM is deselected.
- `ST_RD_STROBE`: the read strobe is held for `WAIT` cycles.
- `ST_WR_SETUP`: one cycle in which the data is driven before the write strobe falls.
- `ST_WR_PULSE`: the write strobe is low for `WAIT` cycles.
- `ST_WR_HOLD`: one cycle in which the data is still driven after the write strobe rises.
- `ST_TURN`: one idle cycle for bus turnaround.

The state machine moves as follows:
- `ST_IDLE` goes to `ST_RD_STROBE` on an accepted read.
- `ST_IDLE` goes to `ST_WR_SETUP` on an accepted write.
- `ST_RD_STROBE` goes to `ST_TURN` on the last wait cycle.
- `ST_WR_SETUP` goes to `ST_WR_PULSE`.
- `ST_WR_PULSE` goes to `ST_WR_HOLD` on the last wait cycle.
- `ST_WR_HOLD` goes to `ST_TURN`.
- `ST_TURN` goes to `ST_IDLE`.

Top module: `sram_async_ctl`

## Requirements
- R1: While `rst_n` is low, independent of the clock, `mem_cs_n`, `mem_rd_n` and `mem_wr_n` are high, `mem_d_drive` is low, `rd_valid` is low and `ready` is high. Asserting reset in the middle of an access ends that access at once.
- R2: Whenever `ready` is high (idle), the RAM is deselected: `mem_cs_n`, `mem_rd_n` and `mem_wr_n` are high and `mem_d_drive` is low.
- R3: A read holds `mem_cs_n` and `mem_rd_n` low, `mem_wr_n` high and `mem_d_drive` low for exactly `WAIT` cycles, with `WAIT = ceil(ACCESS_NS/CLK_NS)+1` (8 by default). `mem_rd_n` is never low outside a read.
- R4: Read data is sampled from `mem_d_in` at the clock edge that ends the last strobe cycle. `rd_valid` is high for exactly one cycle, starting `WAIT` rising edges after the edge that accepted the read.
- R5: `req_be[0]` selects bits 7:0 and drives `mem_lane_sel_n[0]` low. `req_be[1]` selects bits 15:8 and drives `mem_lane_sel_n[1]` low. Unselected lanes read as zero in `rd_data` and are not written in the RAM. All lane selects are high while `mem_cs_n` is high.
- R6: A write has three phases, all with `mem_cs_n` low and `mem_d_drive` high. First comes one setup cycle with `mem_wr_n` high. Then `mem_wr_n` is low for exactly `WAIT` cycles. Last comes one hold cycle with `mem_wr_n` high.
- R7: `mem_a`, `mem_lane_sel_n` and `mem_d_out` stay unchanged for as long as `mem_cs_n` is low. They show the accepted request's address, inverted byte mask and write data.
- R8: A request is accepted on a rising edge where `req_valid` and `ready` are both high. `ready` goes low in the next cycle. It stays low through one idle turnaround cycle after the access, so it is high again `WAIT+1` edges after a read is accepted and `WAIT+3` edges after a write is accepted. Requests presented while `ready` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| ready | output | 1 | Controller idle, request can be accepted |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | 16 | Read data, unselected lanes zero |
| mem_a | output | 17 | RAM word address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_rd_n | output | 1 | RAM read strobe (output enable), active low |
| mem_wr_n | output | 1 | RAM write strobe, active low |
| mem_lane_sel_n | output | 2 | RAM byte-lane selects, active low, bit 0 = low byte |
| mem_d_out | output | 16 | Data to drive onto the RAM data pins |
| mem_d_drive | output | 1 | Enable for the external data pin drivers |
| mem_d_in | input | 16 | Data sampled from the RAM data pins |

## Verification
A corrupted state register or wait counter shows up within one access as a strobe of the wrong width. It can also show up as a strobe that overlaps the data drive, or as a `ready` that returns on the wrong edge, because every strobe and the drive-enable are decoded directly from the state. The bench's memory model returns a poison word until the access time has passed since the read strobe fell. A wait count that is too short therefore shows up as wrong `rd_data` on the very read it affects. Lane-select or latching errors show up when the data is read back after writes with partial masks, normally on the first read after such a write.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_STROBE = 3'd1,
        ST_WR_SETUP  = 3'd2,
        ST_WR_PULSE  = 3'd3,
        ST_WR_HOLD   = 3'd4,
        ST_TURN      = 3'd5
    } sramc_state_e;

    // Strobe length in cycles: access time rounded up to whole cycles, plus one margin cycle.
    function automatic int unsigned wait_cycles(int unsigned clk_ns, int unsigned acc_ns);
        return (acc_ns + clk_ns - 1) / clk_ns + 1;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
`timescale 1ns/1ps
module sramc_timer #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sramc_rdcap.sv
`timescale 1ns/1ps
module sramc_rdcap #(
    parameter int unsigned DW    = 16,
    parameter int unsigned LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    d_in,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid
);
    logic [DW-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*8 +: 8] = be[g] ? d_in[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap;
            if (cap) begin
                rd_data <= masked;
            end
        end
    end

endmodule

// File: rtl/sramc_fsm.sv
`timescale 1ns/1ps
module sramc_fsm
    import sramc_pkg::*;
#(
    parameter int unsigned AW    = 17,
    parameter int unsigned DW    = 16,
    parameter int unsigned LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_be,
    input  logic             last,
    output logic             ready,
    output logic             load,
    output logic             cap,
    output logic [LANES-1:0] be_q,
    output logic [AW-1:0]    mem_a,
    output logic             mem_cs_n,
    output logic             mem_rd_n,
    output logic             mem_wr_n,
    output logic [LANES-1:0] mem_lane_sel_n,
    output logic [DW-1:0]    mem_d_out,
    output logic             mem_d_drive
);
    sramc_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_STROBE;
            ST_RD_STROBE: if (last)      state_d = ST_TURN;
            ST_WR_SETUP:                 state_d = ST_WR_PULSE;
            ST_WR_PULSE:  if (last)      state_d = ST_WR_HOLD;
            ST_WR_HOLD:                  state_d = ST_TURN;
            ST_TURN:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        ready       = 1'b0;
        load        = 1'b0;
        cap         = 1'b0;
        mem_cs_n    = 1'b1;
        mem_rd_n    = 1'b1;
        mem_wr_n    = 1'b1;
        mem_d_drive = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                load  = req_valid && !req_write;
            end
            ST_RD_STROBE: begin
                mem_cs_n = 1'b0;
                mem_rd_n = 1'b0;
                cap      = last;
            end
            ST_WR_SETUP: begin
                mem_cs_n    = 1'b0;
                mem_d_drive = 1'b1;
                load        = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_cs_n    = 1'b0;
                mem_d_drive = 1'b1;
                mem_wr_n    = 1'b0;
            end
            ST_WR_HOLD: begin
                mem_cs_n    = 1'b0;
                mem_d_drive = 1'b1;
            end
            ST_TURN: begin
            end
            default: begin
            end
        endcase
    end

    assign mem_a          = addr_q;
    assign mem_d_out      = wdata_q;
    assign mem_lane_sel_n = mem_cs_n ? {LANES{1'b1}} : ~be_q;

endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl #(
    parameter int unsigned AW        = 17,
    parameter int unsigned DW        = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned ACCESS_NS = 70
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  logic [DW/8-1:0]     req_be,
    output logic                ready,
    output logic                rd_valid,
    output logic [DW-1:0]       rd_data,
    output logic [AW-1:0]       mem_a,
    output logic                mem_cs_n,
    output logic                mem_rd_n,
    output logic                mem_wr_n,
    output logic [DW/8-1:0]     mem_lane_sel_n,
    output logic [DW-1:0]       mem_d_out,
    output logic                mem_d_drive,
    input  logic [DW-1:0]       mem_d_in
);
    localparam int unsigned LANES    = DW / 8;
    localparam int unsigned WAIT_CYC = sramc_pkg::wait_cycles(CLK_NS, ACCESS_NS);

    logic             load;
    logic             last;
    logic             cap;
    logic [LANES-1:0] be_q;

    sramc_fsm #(.AW(AW), .DW(DW), .LANES(LANES)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_be         (req_be),
        .last           (last),
        .ready          (ready),
        .load           (load),
        .cap            (cap),
        .be_q           (be_q),
        .mem_a          (mem_a),
        .mem_cs_n       (mem_cs_n),
        .mem_rd_n       (mem_rd_n),
        .mem_wr_n       (mem_wr_n),
        .mem_lane_sel_n (mem_lane_sel_n),
        .mem_d_out      (mem_d_out),
        .mem_d_drive    (mem_d_drive)
    );

    sramc_timer #(.CYCLES(WAIT_CYC)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .last  (last)
    );

    sramc_rdcap #(.DW(DW), .LANES(LANES)) rdcap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .be       (be_q),
        .d_in     (mem_d_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/sramc_chk.sv
`timescale 1ns/1ps
module sramc_chk #(
    parameter int unsigned AW        = 17,
    parameter int unsigned DW        = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned ACCESS_NS = 70
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ready,
    input logic              rd_valid,
    input logic [AW-1:0]     mem_a,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic [DW/8-1:0]   mem_lane_sel_n,
    input logic [DW-1:0]     mem_d_out,
    input logic              mem_d_drive
);
    localparam int unsigned WAIT_CYC = sramc_pkg::wait_cycles(CLK_NS, ACCESS_NS);

    logic [15:0] rd_low_cnt;
    logic [15:0] wr_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_low_cnt <= '0;
            wr_low_cnt <= '0;
        end else begin
            rd_low_cnt <= mem_rd_n ? 16'd0 : rd_low_cnt + 16'd1;
            wr_low_cnt <= mem_wr_n ? 16'd0 : wr_low_cnt + 16'd1;
        end
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && mem_rd_n && mem_wr_n && !mem_d_drive));

    // R3
    rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!mem_cs_n && mem_wr_n && !mem_d_drive));

    // R3
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |-> (rd_low_cnt == 16'(WAIT_CYC)));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R5
    lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (&mem_lane_sel_n));

    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (mem_d_drive && !mem_cs_n));

    // R6
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> ($past(mem_d_drive) && !$past(mem_cs_n)));

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (mem_d_drive && !mem_cs_n));

    // R6
    wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (wr_low_cnt == 16'(WAIT_CYC)));

    // R7
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |->
            ($stable(mem_a) && $stable(mem_lane_sel_n) && $stable(mem_d_out)));

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

endmodule

bind sram_async_ctl sramc_chk #(
    .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .ACCESS_NS(ACCESS_NS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .ready          (ready),
    .rd_valid       (rd_valid),
    .mem_a          (mem_a),
    .mem_cs_n       (mem_cs_n),
    .mem_rd_n       (mem_rd_n),
    .mem_wr_n       (mem_wr_n),
    .mem_lane_sel_n (mem_lane_sel_n),
    .mem_d_out      (mem_d_out),
    .mem_d_drive    (mem_d_drive)
);

// File: tb/sram_async_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_NS     = 70;
    localparam int AW         = 17;
    localparam int DW         = 16;
    localparam int WAIT       = (ACC_NS + CLK_PERIOD - 1) / CLK_PERIOD + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_be = '0;
    logic          ready, rd_valid, mem_cs_n, mem_rd_n, mem_wr_n, mem_d_drive;
    logic [DW-1:0] rd_data, mem_d_out;
    logic [DW-1:0] mem_d_in = 16'hDEAD;
    logic [AW-1:0] mem_a;
    logic [1:0]    mem_lane_sel_n;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  mon_skip = 1'b1;
    int  wr_len = 0;
    int  rd_len = 0;
    time t_rd_fall = 0;

    logic [15:0] model_mem [int];
    logic [15:0] ref_mem   [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctl #(.AW(AW), .DW(DW), .CLK_NS(CLK_PERIOD), .ACCESS_NS(ACC_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_a(mem_a), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .mem_lane_sel_n(mem_lane_sel_n), .mem_d_out(mem_d_out),
        .mem_d_drive(mem_d_drive), .mem_d_in(mem_d_in)
    );

    function automatic logic [15:0] init_word(int a);
        return 16'((a * 40503) ^ 32'h5A3C);
    endfunction

    function automatic logic [15:0] lane_mask(logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] merge(logic [15:0] old_w, logic [15:0] new_w, logic [1:0] be);
        return (old_w & ~lane_mask(be)) | (new_w & lane_mask(be));
    endfunction

    function automatic logic [15:0] model_rd(int a);
        return model_mem.exists(a) ? model_mem[a] : init_word(a);
    endfunction

    function automatic logic [15:0] ref_rd(int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
    endfunction

    // RAM model: write on the rising write strobe, read data valid only after the access time
    always @(posedge mem_wr_n) begin
        if (rst_n && !mem_cs_n && mem_d_drive)
            model_mem[int'(mem_a)] = merge(model_rd(int'(mem_a)), mem_d_out, ~mem_lane_sel_n);
    end

    always @(negedge mem_rd_n) t_rd_fall = $time;

    always @(negedge clk) begin
        if (!mem_rd_n && !mem_cs_n && ($time - t_rd_fall >= ACC_NS))
            mem_d_in = model_rd(int'(mem_a));
        else
            mem_d_in = 16'hDEAD;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe width monitors (R3, R6)
    always @(negedge clk) begin
        if (mon_skip) begin
            wr_len = 0;
            rd_len = 0;
        end else begin
            if (!mem_wr_n) wr_len++;
            else if (wr_len != 0) begin
                chk(wr_len == WAIT, "R6 write strobe width", wr_len, WAIT);
                wr_len = 0;
            end
            if (!mem_rd_n) rd_len++;
            else if (rd_len != 0) begin
                chk(rd_len == WAIT, "R3 read strobe width", rd_len, WAIT);
                rd_len = 0;
            end
        end
    end

    task automatic do_op(bit wr, int a, logic [15:0] d, logic [1:0] be, bit junk);
        int j;
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
        @(negedge clk);
        chk(!ready, "R8 ready low after accept", ready, 0);
        chk(mem_a == AW'(a), "R7 address presented", mem_a, a);
        chk(mem_lane_sel_n == ~be, "R5 lane selects", mem_lane_sel_n, ~be);
        if (junk) begin
            req_write = 1'b1; req_addr = AW'(32'h0F0F0); req_wdata = 16'hBEEF; req_be = 2'b11;
        end else begin
            req_valid = 1'b0;
        end
        if (wr) begin
            chk(mem_wr_n && mem_d_drive, "R6 setup cycle", {mem_wr_n, mem_d_drive}, 2'b11);
            ref_mem[a] = merge(ref_rd(a), d, be);
            j = 0;
            while (!ready && j < 100) begin @(negedge clk); j++; end
            chk(j == WAIT + 3, "R8 write ready return", j, WAIT + 3);
        end else begin
            j = 0;
            while (!rd_valid && j < 100) begin @(negedge clk); j++; end
            chk(j == WAIT, "R4 read latency", j, WAIT);
            chk(rd_data == (ref_rd(a) & lane_mask(be)), "R4 R5 read data", rd_data, ref_rd(a) & lane_mask(be));
            chk(!ready, "R8 turnaround cycle", ready, 0);
            @(negedge clk);
            chk(!rd_valid, "R4 single pulse", rd_valid, 0);
            chk(ready, "R8 read ready return", ready, 1);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int pool [8] = '{0, 1, 2, 3, 32'h1FFFF, 32'h10000, 32'h0ABC, 32'h0ABD};
        logic [31:0] seed_v;
        seed_v = $urandom(1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_cs_n && mem_rd_n && mem_wr_n && !mem_d_drive && ready && !rd_valid,
            "R1 reset outputs", {mem_cs_n, mem_rd_n, mem_wr_n, mem_d_drive, ready, rd_valid}, 6'b111010);
        rst_n = 1'b1;
        mon_skip = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && mem_rd_n && !mem_d_drive && ready, "R2 idle after reset",
            {mem_cs_n, mem_rd_n, mem_d_drive, ready}, 4'b1101);

        // Directed lane cases (R5)
        do_op(1, 32'h00100, 16'h1234, 2'b11, 0);
        do_op(0, 32'h00100, 16'h0000, 2'b11, 0);
        do_op(1, 32'h00100, 16'hABCD, 2'b01, 0);
        do_op(0, 32'h00100, 16'h0000, 2'b11, 0);
        do_op(1, 32'h00100, 16'h77EE, 2'b10, 0);
        do_op(0, 32'h00100, 16'h0000, 2'b10, 0);
        do_op(0, 32'h00100, 16'h0000, 2'b01, 0);
        do_op(0, 32'h00100, 16'h0000, 2'b00, 0);
        do_op(1, 32'h1FFFF, 16'hC3A5, 2'b11, 0);
        do_op(0, 32'h1FFFF, 16'h0000, 2'b11, 0);
        // Back-to-back read then write (R8 turnaround)
        do_op(0, 32'h00000, 16'h0000, 2'b11, 0);
        do_op(1, 32'h00000, 16'h5A5A, 2'b11, 0);
        // Requests while busy are ignored (R8)
        do_op(1, 32'h00200, 16'h1111, 2'b11, 1);
        do_op(0, 32'h0F0F0, 16'h0000, 2'b11, 0);
        do_op(0, 32'h00200, 16'h0000, 2'b11, 0);

        // Constrained random mix
        for (int i = 0; i < 60; i++) begin
            int a;
            a = pool[$urandom % 8];
            do_op(($urandom % 2) == 1, a, 16'($urandom), 2'($urandom), 0);
        end

        // R1 asynchronous reset in the middle of a write strobe (address never read again)
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(32'h00300); req_wdata = 16'hFFFF; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_wr_n, "R6 strobe active before reset", mem_wr_n, 0);
        mon_skip = 1'b1;
        #1 rst_n = 1'b0;
        #1;
        chk(mem_cs_n && mem_rd_n && mem_wr_n && !mem_d_drive && ready,
            "R1 async reset mid-access", {mem_cs_n, mem_rd_n, mem_wr_n, mem_d_drive, ready}, 5'b11101);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_skip = 1'b0;
        do_op(0, 32'h00100, 16'h0000, 2'b11, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule